// File: doc/BRIEF.md
# Address-Knock ROM Bank Switcher

This block watches the address bus of an 8-bit processor with a 16-bit address and sets which bank of the main system ROM and which bank of the character-generator ROM the board presents. It never looks at bus data. Every command reaches it through the address of an ordinary access, and each access is qualified by a valid strobe, a read/write flag and an opcode-fetch flag. The only addresses it examines are at 0xC080 and above, and it never examines opcode fetches.

A system bank of 0 is the setup bank. While that bank is selected, the block does three things:
- It answers four status addresses itself, by raising an override flag and supplying a byte in place of memory.
- Any access inside one 16-byte window loads the system bank from the low address nibble.
- Any access inside a second 16-byte window loads the text bank the same way.

Selecting a nonzero system bank leaves setup mode at once. To return to setup mode from normal operation, three accesses are needed in order: 0xCACA, then 0xCACA again, then 0xCAFE. This is the knock sequence.

Top module: `rom_bank_switch`

## Requirements
- R1: After reset, the system bank and the text bank are both 0, so the block starts in setup mode, and no override is shown.
- R2: Accesses below 0xC080 never raise the override flag. They do not advance or reset the knock progress, and they do not change either bank.
- R3: Opcode-fetch accesses are ignored. They give no override, do not load a bank, and do not touch knock progress.
- R4: Outside setup mode, the accesses 0xCACA, 0xCACA, 0xCAFE in that order set the system bank to 0, which enters setup mode. Tracking starts again from the first element after each completion and after each exit from setup mode.
- R5: An examined access that does not match the next expected knock address resets the progress to the start. That access is not itself counted as a first element.
- R6: In setup mode, a read of 0xD034 overrides with 0xE0 plus the system bank. A read of 0xD02E overrides with 0xD0 plus the text bank.
- R7: In setup mode, a read of 0xDFFE overrides with 0x4A, and a read of 0xDFFF overrides with 0xCD.
- R8: In setup mode, an access to 0xCEF0–0xCEFF loads the system bank from address bits 3:0. An access to 0xCFD0–0xCFDF loads the text bank from address bits 3:0. Neither access is overridden.
- R9: Writes never raise the override flag. Writes do count as knock elements and as bank-window accesses.
- R10: Outside setup mode, no override is given, and the bank windows have no effect.
- R11: The override flag and byte are combinational in the cycle of the qualifying read. Bank changes are visible after the clock edge that samples the access, so a read just after a nonzero system bank is loaded is no longer overridden.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | Bus address |
| valid_i | input | 1 | Access strobe, one access per cycle while high |
| rd_i | input | 1 | 1 = read, 0 = write |
| fetch_i | input | 1 | 1 = opcode-fetch read |
| ovr_valid_o | output | 1 | Block supplies read data this cycle |
| ovr_data_o | output | 8 | Override byte, meaningful when ovr_valid_o is high |
| sys_bank_o | output | 4 | Selected system ROM bank |
| text_bank_o | output | 4 | Selected character ROM bank |

## Verification
The assertions assume one access per clock, with address, strobe and flags held stable for that whole cycle. They also assume fetch_i is asserted only together with rd_i. The bench drives every access on the falling edge and releases the strobe after the rising edge that samples it. It reads the combinational override midway through the low phase and reads the bank outputs after the rising edge. Opcode fetches in the bench are always reads.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  localparam int ADDR_W  = 16;
  localparam int BANK_W  = 4;
  localparam int DATA_W  = 8;
  localparam int SEQ_LEN = 3;
  localparam int STEP_W  = $clog2(SEQ_LEN);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [BANK_W-1:0] bank_t;
  typedef logic [DATA_W-1:0] byte_t;

  localparam addr_t KNOCK_A = 16'hCACA;
  localparam addr_t KNOCK_B = 16'hCAFE;

  function automatic addr_t knock_addr(input int idx);
    case (idx)
      SEQ_LEN - 1: knock_addr = KNOCK_B;
      default:     knock_addr = KNOCK_A;
    endcase
  endfunction
endpackage

// File: rtl/rbs_knock.sv
module rbs_knock
  import rbs_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  addr_t addr_i,
  input  logic  track_i,   // examined access, not in setup
  input  logic  clear_i,   // examined access while in setup
  output logic  unlock_o
);
  localparam int SLOTS = 1 << STEP_W;

  logic [STEP_W-1:0] step_q;
  logic [SLOTS-1:0]  match;
  logic              hit, last;

  for (genvar k = 0; k < SLOTS; k++) begin : g_match
    if (k < SEQ_LEN) begin : g_live
      assign match[k] = (addr_i == knock_addr(k));
    end else begin : g_pad
      assign match[k] = 1'b0;
    end
  end

  assign hit      = match[step_q];
  assign last     = (step_q == STEP_W'(SEQ_LEN - 1));
  assign unlock_o = track_i & hit & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
    end else if (track_i) begin
      // mismatch restarts without re-testing against element 0
      if (hit && !last) step_q <= step_q + 1'b1;
      else              step_q <= '0;
    end else if (clear_i) begin
      step_q <= '0;
    end
  end
endmodule

// File: rtl/rbs_bank_regs.sv
module rbs_bank_regs
  import rbs_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  unlock_i,
  input  logic  sys_ld_i,
  input  logic  txt_ld_i,
  input  bank_t nibble_i,
  output bank_t sys_bank_o,
  output bank_t text_bank_o
);
  bank_t sys_q, txt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sys_q <= '0;
      txt_q <= '0;
    end else begin
      if (unlock_i)      sys_q <= '0;
      else if (sys_ld_i) sys_q <= nibble_i;
      if (txt_ld_i)      txt_q <= nibble_i;
    end
  end

  assign sys_bank_o  = sys_q;
  assign text_bank_o = txt_q;
endmodule

// File: rtl/rbs_status_mux.sv
module rbs_status_mux
  import rbs_pkg::*;
#(
  parameter addr_t SYS_STAT_A = 16'hD034,
  parameter addr_t TXT_STAT_A = 16'hD02E,
  parameter addr_t ID0_A      = 16'hDFFE,
  parameter addr_t ID1_A      = 16'hDFFF,
  parameter byte_t SYS_TAG    = 8'hE0,
  parameter byte_t TXT_TAG    = 8'hD0,
  parameter byte_t ID0_VAL    = 8'h4A,
  parameter byte_t ID1_VAL    = 8'hCD
) (
  input  addr_t addr_i,
  input  logic  rd_en_i,   // examined read in setup mode
  input  bank_t sys_bank_i,
  input  bank_t text_bank_i,
  output logic  ovr_valid_o,
  output byte_t ovr_data_o
);
  localparam int PAD = DATA_W - BANK_W;

  always_comb begin
    ovr_valid_o = 1'b0;
    ovr_data_o  = '0;
    if (rd_en_i) begin
      ovr_valid_o = 1'b1;
      case (addr_i)
        SYS_STAT_A: ovr_data_o = SYS_TAG + {{PAD{1'b0}}, sys_bank_i};
        TXT_STAT_A: ovr_data_o = TXT_TAG + {{PAD{1'b0}}, text_bank_i};
        ID0_A:      ovr_data_o = ID0_VAL;
        ID1_A:      ovr_data_o = ID1_VAL;
        default:    ovr_valid_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/rom_bank_switch.sv
module rom_bank_switch
  import rbs_pkg::*;
#(
  parameter addr_t LOW_LIMIT = 16'hC080,
  parameter addr_t SYS_WIN   = 16'hCEF0,
  parameter addr_t TXT_WIN   = 16'hCFD0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              valid_i,
  input  logic              rd_i,
  input  logic              fetch_i,
  output logic              ovr_valid_o,
  output logic [DATA_W-1:0] ovr_data_o,
  output logic [BANK_W-1:0] sys_bank_o,
  output logic [BANK_W-1:0] text_bank_o
);
  localparam addr_t WIN_MASK = ~addr_t'((1 << BANK_W) - 1);

  logic  examined, setup, unlock;
  bank_t sys_bank, text_bank;

  assign examined = valid_i & ~fetch_i & (addr_i >= LOW_LIMIT);
  assign setup    = (sys_bank == '0);

  rbs_knock u_knock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .track_i  (examined & ~setup),
    .clear_i  (examined & setup),
    .unlock_o (unlock)
  );

  rbs_bank_regs u_banks (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .unlock_i    (unlock),
    .sys_ld_i    (examined & setup & ((addr_i & WIN_MASK) == SYS_WIN)),
    .txt_ld_i    (examined & setup & ((addr_i & WIN_MASK) == TXT_WIN)),
    .nibble_i    (addr_i[BANK_W-1:0]),
    .sys_bank_o  (sys_bank),
    .text_bank_o (text_bank)
  );

  rbs_status_mux u_stat (
    .addr_i      (addr_i),
    .rd_en_i     (examined & setup & rd_i),
    .sys_bank_i  (sys_bank),
    .text_bank_i (text_bank),
    .ovr_valid_o (ovr_valid_o),
    .ovr_data_o  (ovr_data_o)
  );

  assign sys_bank_o  = sys_bank;
  assign text_bank_o = text_bank;
endmodule

// File: rtl/rom_bank_switch_chk.sv
module rom_bank_switch_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] addr_i,
  input logic        valid_i,
  input logic        rd_i,
  input logic        fetch_i,
  input logic        ovr_valid_o,
  input logic [7:0]  ovr_data_o,
  input logic [3:0]  sys_bank_o,
  input logic [3:0]  text_bank_o
);
  // R2
  low_addr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i < 16'hC080) |-> !ovr_valid_o);

  // R3
  fetch_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_i |-> !ovr_valid_o);

  // R9
  write_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> !ovr_valid_o);

  // R10
  ovr_only_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_valid_o |-> (sys_bank_o == 4'd0));

  // R7
  id_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rd_i && !fetch_i && sys_bank_o == 4'd0 && addr_i == 16'hDFFE)
    |-> (ovr_valid_o && ovr_data_o == 8'h4A));

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(sys_bank_o) && $stable(text_bank_o)));

  // R10
  text_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_bank_o != 4'd0) |=> $stable(text_bank_o));
endmodule

bind rom_bank_switch rom_bank_switch_chk u_rom_bank_switch_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .valid_i     (valid_i),
  .rd_i        (rd_i),
  .fetch_i     (fetch_i),
  .ovr_valid_o (ovr_valid_o),
  .ovr_data_o  (ovr_data_o),
  .sys_bank_o  (sys_bank_o),
  .text_bank_o (text_bank_o)
);

// File: tb/rom_bank_switch_bench.sv
module rom_bank_switch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        valid = 1'b0, rd = 1'b1, fetch = 1'b0;
  logic        ovr_v;
  logic [7:0]  ovr_d;
  logic [3:0]  sys_b, txt_b;
  int          checks = 0, errors = 0;
  logic        got_v;
  logic [7:0]  got_d;

  always #4 clk = ~clk;

  rom_bank_switch u_rom_bank_switch (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .valid_i(valid),
    .rd_i(rd), .fetch_i(fetch), .ovr_valid_o(ovr_v), .ovr_data_o(ovr_d),
    .sys_bank_o(sys_b), .text_bank_o(txt_b));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one access; override sampled mid low phase, banks settle after the edge
  task automatic acc(input logic [15:0] a, input logic r, input logic f);
    @(negedge clk);
    addr = a; rd = r; fetch = f; valid = 1'b1;
    #2;
    got_v = ovr_v; got_d = ovr_d;
    @(posedge clk); #1;
    valid = 1'b0; rd = 1'b1; fetch = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 sys", {12'd0, sys_b}, 16'd0);
    chk("R1 text", {12'd0, txt_b}, 16'd0);
    chk("R1 ovr", {15'd0, ovr_v}, 16'd0);
  endtask

  task automatic t_status;
    acc(16'hD034, 1, 0); chk("R6 sys stat", {7'd0, got_v, got_d}, 16'h01E0);
    acc(16'hD02E, 1, 0); chk("R6 txt stat", {7'd0, got_v, got_d}, 16'h01D0);
    acc(16'hDFFE, 1, 0); chk("R7 id0", {7'd0, got_v, got_d}, 16'h014A);
    acc(16'hDFFF, 1, 0); chk("R7 id1", {7'd0, got_v, got_d}, 16'h01CD);
    acc(16'hD034, 0, 0); chk("R9 write no ovr", {15'd0, got_v}, 16'd0);
    acc(16'hD034, 1, 1); chk("R3 fetch no ovr", {15'd0, got_v}, 16'd0);
    acc(16'h1034, 1, 0); chk("R2 low no ovr", {15'd0, got_v}, 16'd0);
  endtask

  task automatic t_banks;
    acc(16'hCFD5, 1, 0); chk("R8 txt win no ovr", {15'd0, got_v}, 16'd0);
    chk("R8 txt load", {12'd0, txt_b}, 16'd5);
    acc(16'hD02E, 1, 0); chk("R6 txt stat 5", {7'd0, got_v, got_d}, 16'h01D5);
    acc(16'hCFD9, 0, 0); chk("R9 write loads txt", {12'd0, txt_b}, 16'd9);
    acc(16'hCFD2, 1, 1); chk("R3 fetch no load", {12'd0, txt_b}, 16'd9);
    acc(16'h0FD2, 1, 0); chk("R2 low no load", {12'd0, txt_b}, 16'd9);
    acc(16'hCEF7, 1, 0); chk("R8 sys load", {12'd0, sys_b}, 16'd7);
    chk("R8 sys win no ovr", {15'd0, got_v}, 16'd0);
    acc(16'hD034, 1, 0); chk("R11 left setup", {15'd0, got_v}, 16'd0);
    acc(16'hDFFF, 1, 0); chk("R10 no id", {15'd0, got_v}, 16'd0);
    acc(16'hCFD1, 1, 0); chk("R10 txt locked", {12'd0, txt_b}, 16'd9);
    acc(16'hCEF2, 1, 0); chk("R10 sys locked", {12'd0, sys_b}, 16'd7);
  endtask

  task automatic t_unlock;
    acc(16'hCACA, 1, 0); acc(16'h1234, 1, 0);
    acc(16'hCACA, 1, 0); chk("R4 not yet", {12'd0, sys_b}, 16'd7);
    acc(16'hCAFE, 0, 0); chk("R4 R9 unlocked by write", {12'd0, sys_b}, 16'd0);
    acc(16'hD034, 1, 0); chk("R4 setup stat", {7'd0, got_v, got_d}, 16'h01E0);
    acc(16'hCEF3, 1, 0); chk("R8 sys 3", {12'd0, sys_b}, 16'd3);
  endtask

  task automatic t_mismatch;
    acc(16'hCACA, 1, 0); acc(16'hCACA, 1, 0); acc(16'hCACA, 1, 0);
    acc(16'hCAFE, 1, 0); chk("R5 third caca not recounted", {12'd0, sys_b}, 16'd3);
    acc(16'hCACA, 1, 0); acc(16'hD000, 1, 0); acc(16'hCACA, 1, 0);
    acc(16'hCAFE, 1, 0); chk("R5 mismatch restart", {12'd0, sys_b}, 16'd3);
    acc(16'hCACA, 1, 0); acc(16'hCAFE, 1, 1); acc(16'hCACA, 1, 0);
    acc(16'hCAFE, 1, 0); chk("R3 fetch skipped in knock", {12'd0, sys_b}, 16'd0);
    acc(16'hCEF1, 0, 0);
    acc(16'hCACA, 1, 0); acc(16'hCACA, 1, 0);
    acc(16'hCAFE, 1, 0); chk("R4 second unlock", {12'd0, sys_b}, 16'd0);
  endtask

  initial begin
    #20;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_status();
    t_banks();
    t_unlock();
    t_mismatch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule